// File: doc/BRIEF.md
# Receive Offset Calibration Sequencer

This block orders the start-up of a dual receive converter channel. When the receive enable is raised, it waits for the analog front end to settle, waits a first programmable delay, and can then run an offset calibration with the converter inputs optionally tied together. After that it waits for the decimation filter to settle and for a second programmable delay, and then raises a ready flag. The converter core, the offset store and the correction arithmetic are outside the block. The block only tells the core when to calibrate (`cal_strobe`) and whether its inputs must be shorted (`short_sel`).

Every interval is a whole number of ticks. A prescaler divides the master clock by `TICK_CLKS` (48 by default) to make the tick. The counter is reloaded at each state change, so a state whose interval is N ticks lasts exactly 48·N + 1 clocks. The extra clock is the cycle in which the state is entered. The filter-settling phase does not count from zero. Its counter is loaded with 36 and the phase ends when the count reaches 40, which gives four ticks. Dropping the receive enable aborts the sequence from any state.

Top module: `rx_cal_seq`

## Requirements
- R1: After a synchronous active-low reset, `ready`, `short_sel` and `cal_strobe` are 0, and the sequencer is idle until `rx_en` is sampled high.
- R2: The tick is one clock in every `TICK_CLKS` clocks (48). A phase of N ticks occupies 48·N+1 clocks.
- R3: From `rx_en` rising while idle, the phases run in this order: power-up settle (`SETTLE_TICKS`=2), delay 1, optional calibration, filter settle, delay 2. `ready` is first seen high 1 + 97 + (48·d1+1) + cal + 193 + (48·d2+1) clocks after `rx_en` is driven high, where cal is 145 when calibration runs and 0 when it is skipped.
- R4: `dly1` accepts 0 to 255 ticks. It is captured when delay 1 is entered, and later changes have no effect on the running sequence.
- R5: `dly2` accepts 0 to 255 ticks, with the full range including 255 working.
- R6: When `auto_cal`=1, `cal_strobe` is a single one-clock pulse on the first clock of the calibration phase. That first clock is 99 + 48·d1 clocks after `rx_en` is driven. `short_sel` is high for the whole phase, 48·`CAL_TICKS`+1 = 145 clocks, and is low once the phase ends.
- R7: When `auto_cal`=0 and `ext_cal`=1, the calibration phase runs and `cal_strobe` pulses once, but `short_sel` stays 0.
- R8: When both `auto_cal` and `ext_cal` are 0, the calibration phase is skipped, and `cal_strobe` and `short_sel` stay 0.
- R9: The filter-settle counter starts at 36 and ends at 40, so the phase lasts 4 ticks (193 clocks) whether or not calibration ran.
- R10: `ready` stays high while `rx_en` stays high. When `rx_en` is low at a clock edge, after that edge `ready`, `short_sel` and `cal_strobe` are 0 and the sequencer is idle. A new rising `rx_en` restarts the full sequence.
- R11: When both `auto_cal` and `ext_cal` are 1, the internal-short calibration (R6) takes priority.
- R12: The calibration bits are sampled at the end of delay 1. A change made during delay 1 takes effect, and a change made during calibration does not alter that calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; low aborts to idle |
| auto_cal | input | 1 | Run calibration with inputs shorted |
| ext_cal | input | 1 | Run calibration with inputs left connected |
| dly1 | input | 8 | Delay before calibration, in ticks |
| dly2 | input | 8 | Delay before ready, in ticks |
| short_sel | output | 1 | Tie converter inputs together |
| cal_strobe | output | 1 | One-clock calibrate command to the core |
| ready | output | 1 | Receive data valid |

## Verification
The hardest case to reach from the ports is a change of a programmed value or a calibration bit inside a specific phase. The capture-at-entry and sample-at-exit rules can only be seen that way. The bench counts clocks from the rising enable, using the R3 phase lengths, and changes `dly1` or the calibration bits at a chosen clock. The chosen clock falls in the middle of delay 1 or of calibration. The bench then compares the ready latency, the strobe count and the number of shorted clocks against the values the unchanged or changed settings predict. An abort is placed in the middle of calibration in the same way, by counting to a clock known to lie in that phase.

// File: rtl/rxcal_pkg.sv
// Package: shared state encoding for the receive calibration sequencer.
// Assumes: the state order below matches the phase order in the brief.
package rxcal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_DLY1   = 3'd2,
        ST_CAL    = 3'd3,
        ST_FILT   = 3'd4,
        ST_DLY2   = 3'd5,
        ST_READY  = 3'd6
    } rxcal_state_t;
endpackage

// File: rtl/rxcal_prescaler.sv
// Module: divides the master clock into a one-clock tick every TICK_CLKS
// clocks. A clear restarts the division so that the next tick arrives
// TICK_CLKS clocks after the clear is released.
// Assumes: TICK_CLKS >= 1.
module rxcal_prescaler #(
    parameter int TICK_CLKS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (TICK_CLKS > 1) begin : g_div
            localparam int PW = $clog2(TICK_CLKS);
            localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);
            logic [PW-1:0] pcnt;

            // Purpose: flag the final clock of each division period.
            assign tick = (pcnt == LAST);

            // Purpose: advance the division counter, wrapping on the tick.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    pcnt <= '0;
                end else if (tick) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end else begin : g_pass
            // Purpose: with no division every clock is a tick.
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/rxcal_interval_ctr.sv
// Module: phase interval counter. On load it captures a start count and an
// end count. It then advances once per tick, and done is high while the
// count equals the captured end count.
// Assumes: start <= limit at every load, so the count never passes the end.
module rxcal_interval_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] limit,
    input  logic          tick,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Purpose: load on phase entry, otherwise count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= '0;
        end else if (load) begin
            cnt <= start;
            lim <= limit;
        end else if (tick && (cnt != lim)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Purpose: report that the phase has run its full length.
    assign done = (cnt == lim);
endmodule

// File: rtl/rxcal_fsm.sv
// Module: sequence control. It walks through the phases, chooses the counter
// start and end for each phase, and drives the converter-facing outputs.
// Assumes: done comes from a counter loaded on every state change, and
// dly1/dly2 are only captured by that counter at phase entry.
module rxcal_fsm
    import rxcal_pkg::*;
#(
    parameter int CW           = 8,
    parameter int SETTLE_TICKS = 2,
    parameter int CAL_TICKS    = 3,
    parameter int FILT_START   = 36,
    parameter int FILT_END     = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          auto_cal,
    input  logic          ext_cal,
    input  logic [CW-1:0] dly1,
    input  logic [CW-1:0] dly2,
    input  logic          done,
    output rxcal_state_t  state,
    output logic          load,
    output logic [CW-1:0] start,
    output logic [CW-1:0] limit,
    output logic          pre_clr,
    output logic          short_sel,
    output logic          cal_strobe,
    output logic          ready
);
    localparam logic [CW-1:0] SETTLE_LIM = CW'(SETTLE_TICKS);
    localparam logic [CW-1:0] CAL_LIM    = CW'(CAL_TICKS);
    localparam logic [CW-1:0] FILT_LO    = CW'(FILT_START);
    localparam logic [CW-1:0] FILT_HI    = CW'(FILT_END);

    rxcal_state_t nxt;
    logic         short_en;
    logic         cal_req;

    // Purpose: either calibration bit requests the calibration phase.
    assign cal_req = auto_cal | ext_cal;

    // Purpose: choose the next phase; a low enable wins over everything.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (rx_en) nxt = ST_SETTLE;
            ST_SETTLE: if (done)  nxt = ST_DLY1;
            ST_DLY1:   if (done)  nxt = cal_req ? ST_CAL : ST_FILT;
            ST_CAL:    if (done)  nxt = ST_FILT;
            ST_FILT:   if (done)  nxt = ST_DLY2;
            ST_DLY2:   if (done)  nxt = ST_READY;
            ST_READY:  nxt = ST_READY;
            default:   nxt = ST_IDLE;
        endcase
        if (!rx_en) nxt = ST_IDLE;
    end

    // Purpose: pick the counter start and end for the phase being entered.
    always_comb begin
        start = '0;
        limit = '0;
        unique case (nxt)
            ST_SETTLE: limit = SETTLE_LIM;
            ST_DLY1:   limit = dly1;
            ST_CAL:    limit = CAL_LIM;
            ST_FILT: begin
                start = FILT_LO;
                limit = FILT_HI;
            end
            ST_DLY2:   limit = dly2;
            default:   limit = '0;
        endcase
    end

    // Purpose: reload the counter and prescaler on every phase change.
    assign load    = (nxt != state);
    assign pre_clr = load || (state == ST_IDLE);

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Purpose: latch the short choice as delay 1 ends; auto has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_en <= 1'b0;
        end else if (state == ST_DLY1 && nxt == ST_CAL) begin
            short_en <= auto_cal;
        end
    end

    // Purpose: one-clock calibrate command on entry to the calibration phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_strobe <= 1'b0;
        end else begin
            cal_strobe <= (nxt == ST_CAL) && (state != ST_CAL);
        end
    end

    // Purpose: outputs decoded from the registered state.
    assign short_sel = (state == ST_CAL) && short_en;
    assign ready     = (state == ST_READY);
endmodule

// File: rtl/rx_cal_seq.sv
// Module: top level of the receive offset calibration sequencer. It connects
// the tick prescaler, the phase interval counter and the sequence control.
// Assumes: a synchronous active-low reset and a single master clock.
module rx_cal_seq
    import rxcal_pkg::*;
#(
    parameter int TICK_CLKS    = 48,
    parameter int DLY_W        = 8,
    parameter int SETTLE_TICKS = 2,
    parameter int CAL_TICKS    = 3,
    parameter int FILT_START   = 36,
    parameter int FILT_END     = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             auto_cal,
    input  logic             ext_cal,
    input  logic [DLY_W-1:0] dly1,
    input  logic [DLY_W-1:0] dly2,
    output logic             short_sel,
    output logic             cal_strobe,
    output logic             ready
);
    localparam int CW = DLY_W;

    rxcal_state_t  state;
    logic          tick;
    logic          done;
    logic          load;
    logic          pre_clr;
    logic [CW-1:0] start;
    logic [CW-1:0] limit;

    rxcal_prescaler #(.TICK_CLKS(TICK_CLKS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .tick  (tick)
    );

    rxcal_interval_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .start (start),
        .limit (limit),
        .tick  (tick),
        .done  (done)
    );

    rxcal_fsm #(
        .CW           (CW),
        .SETTLE_TICKS (SETTLE_TICKS),
        .CAL_TICKS    (CAL_TICKS),
        .FILT_START   (FILT_START),
        .FILT_END     (FILT_END)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .auto_cal   (auto_cal),
        .ext_cal    (ext_cal),
        .dly1       (dly1),
        .dly2       (dly2),
        .done       (done),
        .state      (state),
        .load       (load),
        .start      (start),
        .limit      (limit),
        .pre_clr    (pre_clr),
        .short_sel  (short_sel),
        .cal_strobe (cal_strobe),
        .ready      (ready)
    );
endmodule

// File: rtl/rx_cal_seq_chk.sv
// Module: property checker for rx_cal_seq, attached with the bind below.
// Assumes: it observes the top-level ports plus the internal tick and state.
module rx_cal_seq_chk
    import rxcal_pkg::*;
#(
    parameter int TICK_CLKS = 48
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rx_en,
    input logic         short_sel,
    input logic         cal_strobe,
    input logic         ready,
    input logic         tick,
    input rxcal_state_t state
);
    // R10: a low enable clears every output by the next clock
    assert_idle_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!ready && !short_sel && !cal_strobe));

    // R10: ready is held while the enable stays high
    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rx_en) |=> ready);

    // R6: the calibrate command lasts one clock
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_strobe |=> !cal_strobe);

    // R6: inputs are never shorted while data is reported ready
    assert_short_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        short_sel |-> !ready);

    // R3: ready can only rise out of the second delay
    assert_ready_after_dly2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(state) == ST_DLY2));

    generate
        if (TICK_CLKS > 1) begin : g_tick_chk
            // R2: ticks are never on adjacent clocks
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

bind rx_cal_seq rx_cal_seq_chk #(.TICK_CLKS(TICK_CLKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .short_sel  (short_sel),
    .cal_strobe (cal_strobe),
    .ready      (ready),
    .tick       (tick),
    .state      (state)
);

// File: tb/rx_cal_seq_tb.sv
`timescale 1ns/1ps
module rx_cal_seq_tb;
    // Expected phase lengths from the requirements (48-clock tick).
    localparam int TK      = 48;
    localparam int SETTLE  = 2 * TK + 1;   // 97
    localparam int CALLEN  = 3 * TK + 1;   // 145
    localparam int FILTLEN = 4 * TK + 1;   // 193

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       auto_cal = 1'b0;
    logic       ext_cal = 1'b0;
    logic [7:0] dly1 = '0;
    logic [7:0] dly2 = '0;
    logic       short_sel;
    logic       cal_strobe;
    logic       ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_all = 1'b0;

    always #2 clk = ~clk;

    rx_cal_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .auto_cal   (auto_cal),
        .ext_cal    (ext_cal),
        .dly1       (dly1),
        .dly2       (dly2),
        .short_sel  (short_sel),
        .cal_strobe (cal_strobe),
        .ready      (ready)
    );

    function automatic int exp_lat(int a, int b, bit cal);
        return 1 + SETTLE + (TK * a + 1) + (cal ? CALLEN : 0) + FILTLEN + (TK * b + 1);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drop the enable and let the sequencer return to idle.
    task automatic go_idle();
        @(negedge clk);
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Start a sequence; optionally change inputs at sample chg_at.
    task automatic run_seq(input logic [7:0] a, input logic [7:0] b,
                           input bit au, input bit ex, input int chg_at,
                           input logic [7:0] na, input bit nau, input bit nex,
                           output int lat, output int strobes,
                           output int spos, output int shorts);
        int n;
        n = 0; lat = -1; strobes = 0; spos = -1; shorts = 0;
        dly1 = a; dly2 = b; auto_cal = au; ext_cal = ex;
        rx_en = 1'b1;
        while (n < 30000) begin
            @(negedge clk);
            n++;
            if (cal_strobe) begin
                strobes++;
                if (spos < 0) spos = n;
            end
            if (short_sel) shorts++;
            if (ready) begin
                lat = n;
                break;
            end
            if (n == chg_at) begin
                dly1 = na; auto_cal = nau; ext_cal = nex;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1", "ready after reset", int'(ready), 0);
        chk("R1", "short_sel after reset", int'(short_sel), 0);
        chk("R1", "cal_strobe after reset", int'(cal_strobe), 0);
        repeat (200) @(negedge clk);
        chk("R1", "ready stays low while idle", int'(ready), 0);
    endtask

    task automatic t_auto();
        int lat, st, sp, sh;
        run_seq(8'd0, 8'd0, 1'b1, 1'b0, -1, 8'd0, 1'b1, 1'b0, lat, st, sp, sh);
        chk("R3", "auto latency d1=0 d2=0", lat, exp_lat(0, 0, 1'b1));
        chk("R6", "strobe count", st, 1);
        chk("R6", "strobe position", sp, 99);
        chk("R6", "shorted clocks", sh, CALLEN);
        chk("R6", "short low after cal", int'(short_sel), 0);
        go_idle();
    endtask

    task automatic t_ext();
        int lat, st, sp, sh;
        run_seq(8'd3, 8'd2, 1'b0, 1'b1, -1, 8'd3, 1'b0, 1'b1, lat, st, sp, sh);
        chk("R7", "ext latency", lat, exp_lat(3, 2, 1'b1));
        chk("R7", "ext strobe count", st, 1);
        chk("R7", "ext strobe position", sp, 99 + TK * 3);
        chk("R7", "ext shorted clocks", sh, 0);
        go_idle();
    endtask

    task automatic t_none();
        int lat, st, sp, sh;
        run_seq(8'd1, 8'd1, 1'b0, 1'b0, -1, 8'd1, 1'b0, 1'b0, lat, st, sp, sh);
        // R9: filter settle still 193 clocks with calibration skipped
        chk("R8", "no-cal latency", lat, exp_lat(1, 1, 1'b0));
        chk("R8", "no-cal strobe count", st, 0);
        chk("R8", "no-cal shorted clocks", sh, 0);
        chk("R9", "filter length via latency", lat - (1 + SETTLE + 49 + 49), FILTLEN);
        go_idle();
    endtask

    task automatic t_both();
        int lat, st, sp, sh;
        run_seq(8'd2, 8'd0, 1'b1, 1'b1, -1, 8'd2, 1'b1, 1'b1, lat, st, sp, sh);
        chk("R11", "both bits shorted clocks", sh, CALLEN);
        chk("R11", "both bits strobe count", st, 1);
        go_idle();
    endtask

    task automatic t_max();
        int lat, st, sp, sh;
        run_seq(8'd255, 8'd255, 1'b1, 1'b0, -1, 8'd255, 1'b1, 1'b0, lat, st, sp, sh);
        chk("R4", "d1=255 strobe position", sp, 99 + TK * 255);
        chk("R5", "d1=255 d2=255 latency", lat, exp_lat(255, 255, 1'b1));
        go_idle();
    endtask

    task automatic t_capture();
        int lat, st, sp, sh;
        // Delay 1 occupies samples 98..338 for d1=5; change at 150 must be ignored.
        run_seq(8'd5, 8'd0, 1'b0, 1'b0, 150, 8'd0, 1'b0, 1'b0, lat, st, sp, sh);
        chk("R4", "dly1 change mid-phase ignored", lat, exp_lat(5, 0, 1'b0));
        go_idle();
        // R12: auto set during delay 1 takes effect.
        run_seq(8'd5, 8'd0, 1'b0, 1'b0, 150, 8'd5, 1'b1, 1'b0, lat, st, sp, sh);
        chk("R12", "auto set in delay1 shorts", sh, CALLEN);
        chk("R12", "auto set in delay1 latency", lat, exp_lat(5, 0, 1'b1));
        go_idle();
        // R12: bits cleared during calibration do not alter it.
        run_seq(8'd0, 8'd0, 1'b1, 1'b0, 110, 8'd0, 1'b0, 1'b0, lat, st, sp, sh);
        chk("R12", "auto cleared in cal shorts", sh, CALLEN);
        go_idle();
    endtask

    task automatic t_hold_abort();
        int lat, st, sp, sh;
        run_seq(8'd0, 8'd0, 1'b1, 1'b0, -1, 8'd0, 1'b1, 1'b0, lat, st, sp, sh);
        repeat (100) @(negedge clk);
        chk("R10", "ready held", int'(ready), 1);
        go_idle();
        chk("R10", "ready low after disable", int'(ready), 0);
        // Abort in the middle of calibration.
        dly1 = 8'd0; dly2 = 8'd0; auto_cal = 1'b1; ext_cal = 1'b0;
        rx_en = 1'b1;
        repeat (120) @(negedge clk);
        chk("R10", "short high mid-cal", int'(short_sel), 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk("R10", "short cleared one clock after disable", int'(short_sel), 0);
        chk("R10", "ready low after abort", int'(ready), 0);
        repeat (2) @(negedge clk);
        run_seq(8'd0, 8'd0, 1'b1, 1'b0, -1, 8'd0, 1'b1, 1'b0, lat, st, sp, sh);
        chk("R10", "restart full latency", lat, exp_lat(0, 0, 1'b1));
        chk("R2", "phase length from tick", sp - 1 - SETTLE, 1);
        go_idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_auto();
        t_ext();
        t_none();
        t_both();
        t_capture();
        t_hold_abort();
        t_max();
        if (!done_all) begin
            done_all = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_all) begin
            done_all = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule